// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the management-side master of a two-wire MDIO bus. It produces the MDC clock and moves one management frame at a time to or from an external PHY. Software first sets a framing mode, clause 22 or clause 45, and a preamble enable. It then loads a 16-bit payload register and writes a command made of an opcode, a PHY address and a register or device address. The command write starts the frame.

One 2-bit opcode field is decoded according to the mode bit. The block then builds the start code and the wire opcode, shifts the frame out MSB first and handles the turnaround. On reads it samples the PHY's reply. Two separate status groups report progress. A write-side pending flag covers write and address frames. A read-side group holds a pending flag, a valid flag and the 16 returned bits.

Top module: `mdio_station_master`

## Requirements
- R1: After reset the write-side pending flag, the read-side pending flag and the read valid flag are all 0, MDC is low and the MDIO output enable is 0.
- R2: With the mode bit at 0 (clause 22), opcode 0 sends a write frame with start code 01 and wire opcode 01, and opcode 1 sends a read frame with start code 01 and wire opcode 10.
- R3: With the mode bit at 1 (clause 45), opcode 0 sends an address frame with wire opcode 00, opcode 1 a write with 01 and opcode 3 a read with 11, all with start code 00. The address field then carries the device address.
- R4: With the preamble enable set, a frame begins with 32 MDC cycles of MDIO driven high. With it clear, the frame begins directly with the start code.
- R5: Write and address frames send, after the start code, the wire opcode, the 5-bit PHY address and the 5-bit register/device address, a driven turnaround of 1 then 0, and then the 16 bits of the payload register, MSB first.
- R6: A write or address command raises the write-side pending flag on the clock edge that accepts it. The flag stays set until the last payload bit has been clocked out.
- R7: A read command raises the read-side pending flag and clears valid. The output enable is released for both turnaround bits and all 16 data bits. The 16 sampled bits are stored, and valid is set only if the PHY drove 0 on the second turnaround bit.
- R8: A command written while either pending flag is set is ignored. It starts no frame and changes neither pending flag.
- R9: The opcodes that have no meaning start no frame and leave both pending flags at 0: opcodes 2 and 3 in clause 22, opcode 2 in clause 45.
- R10: MDC is low while idle and each of its phases lasts HALF_DIV system clocks, which gives a 400 ns period at the defaults. MDIO changes only together with an MDC falling edge, and input bits are sampled on MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the configuration register |
| cfg_c45 | input | 1 | Mode bit: 1 selects clause 45, 0 selects clause 22 |
| cfg_pre_en | input | 1 | Enable the 32-bit preamble |
| wd_we | input | 1 | Load the payload register |
| wd_value | input | 16 | Payload for write and address frames |
| cmd_we | input | 1 | Command write; starts one frame |
| cmd_op | input | 2 | Opcode, decoded according to the mode bit |
| cmd_phy | input | 5 | PHY address |
| cmd_addr | input | 5 | Register address (clause 22) or device address (clause 45) |
| wr_pending | output | 1 | Write or address frame in progress |
| rd_pending | output | 1 | Read frame in progress |
| rd_valid | output | 1 | Last read returned usable data |
| rd_data | output | 16 | Data from the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
The checker watches four things on every cycle. The two pending flags are never set together, and a command arriving under one pending flag cannot raise the other. The bus is released with MDC low whenever nothing is pending. MDIO changes only on an MDC falling edge, and each MDC phase lasts at least HALF_DIV clocks. The bench's scenarios are needed to show the exact bit sequence of each frame type with and without a preamble, the mapping of opcodes to wire codes in both modes, and that valid follows the PHY's second turnaround bit. They also show that a command issued during a frame, or one with an unused opcode, leaves no trace.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int POS_W      = $clog2(PRE_BITS + FRAME_BITS);
    localparam int FIDX_W     = $clog2(FRAME_BITS);

    localparam logic [POS_W-1:0] POS_TA_HI  = POS_W'(17);
    localparam logic [POS_W-1:0] POS_TA_LO  = POS_W'(16);
    localparam logic [POS_W-1:0] POS_LAST   = '0;
    localparam logic [POS_W-1:0] POS_FIRST_PRE = POS_W'(PRE_BITS + FRAME_BITS - 1);
    localparam logic [POS_W-1:0] POS_FIRST_NOPRE = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [1:0]  ta;
        logic [15:0] data;
    } mdio_frame_t;

    typedef struct packed {
        logic       legal;
        logic       is_read;
        logic [1:0] start_bits;
        logic [1:0] wire_op;
    } op_decode_t;

    function automatic op_decode_t decode_op(input logic c45, input logic [1:0] op);
        op_decode_t d;
        d = '0;
        if (c45) begin
            d.start_bits = 2'b00;
            unique case (op)
                2'd0: begin d.legal = 1'b1; d.wire_op = 2'b00; end
                2'd1: begin d.legal = 1'b1; d.wire_op = 2'b01; end
                2'd3: begin d.legal = 1'b1; d.wire_op = 2'b11; d.is_read = 1'b1; end
                default: d.legal = 1'b0;
            endcase
        end else begin
            d.start_bits = 2'b01;
            unique case (op)
                2'd0: begin d.legal = 1'b1; d.wire_op = 2'b01; end
                2'd1: begin d.legal = 1'b1; d.wire_op = 2'b10; d.is_read = 1'b1; end
                default: d.legal = 1'b0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          term;

    assign term = run && (cnt == TERM);
    assign rise = term && !mdc;
    assign fall = term && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == TERM) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_frame_t frame_in,
    input  logic        is_read,
    input  logic        pre_en,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        rx_ok,
    output logic [15:0] rx_data
);
    mdio_frame_t      frame_q;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] nxt;
    logic             rd_q;

    function automatic logic bit_at(input mdio_frame_t f, input logic [POS_W-1:0] p);
        if (p >= POS_W'(FRAME_BITS)) return 1'b1;
        return f[p[FIDX_W-1:0]];
    endfunction

    assign nxt  = pos - 1'b1;
    assign done = busy && fall && (pos == POS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            pos     <= '0;
            frame_q <= '0;
            rd_q    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rx_ok   <= 1'b0;
            rx_data <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                frame_q <= frame_in;
                rd_q    <= is_read;
                pos     <= pre_en ? POS_FIRST_PRE : POS_FIRST_NOPRE;
                mdio_o  <= pre_en ? 1'b1 : frame_in.st[1];
                mdio_oe <= 1'b1;
                rx_ok   <= 1'b0;
            end
        end else begin
            if (rise && rd_q) begin
                if (pos == POS_TA_LO)
                    rx_ok <= !mdio_i;
                else if (pos < POS_TA_LO)
                    rx_data <= {rx_data[14:0], mdio_i};
            end
            if (fall) begin
                if (pos == POS_LAST) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b1;
                end else begin
                    pos     <= nxt;
                    mdio_o  <= bit_at(frame_q, nxt);
                    mdio_oe <= !(rd_q && (nxt <= POS_TA_HI));
                end
            end
        end
    end
endmodule

// File: rtl/mdio_station_master.sv
module mdio_station_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_c45,
    input  logic        cfg_pre_en,
    input  logic        wd_we,
    input  logic [15:0] wd_value,
    input  logic        cmd_we,
    input  logic [1:0]  cmd_op,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_addr,
    output logic        wr_pending,
    output logic        rd_pending,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        c45_q;
    logic        pre_q;
    logic [15:0] wd_q;
    op_decode_t  dec;
    mdio_frame_t frame_new;
    logic        accept;
    logic        busy, rise, fall, done, rx_ok;
    logic [15:0] rx_data;

    assign dec    = decode_op(c45_q, cmd_op);
    assign accept = cmd_we && dec.legal && !wr_pending && !rd_pending;

    always_comb begin
        frame_new       = '0;
        frame_new.st    = dec.start_bits;
        frame_new.op    = dec.wire_op;
        frame_new.phy   = cmd_phy;
        frame_new.regad = cmd_addr;
        frame_new.ta    = 2'b10;
        frame_new.data  = wd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c45_q <= 1'b0;
            pre_q <= 1'b1;
            wd_q  <= '0;
        end else begin
            if (cfg_we) begin
                c45_q <= cfg_c45;
                pre_q <= cfg_pre_en;
            end
            if (wd_we) wd_q <= wd_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pending <= 1'b0;
            rd_pending <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else if (accept) begin
            if (dec.is_read) begin
                rd_pending <= 1'b1;
                rd_valid   <= 1'b0;
            end else begin
                wr_pending <= 1'b1;
            end
        end else if (done) begin
            wr_pending <= 1'b0;
            rd_pending <= 1'b0;
            if (rd_pending) begin
                rd_valid <= rx_ok;
                rd_data  <= rx_data;
            end
        end
    end

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .frame_in (frame_new),
        .is_read  (dec.is_read),
        .pre_en   (pre_q),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rx_ok    (rx_ok),
        .rx_data  (rx_data)
    );
endmodule

// File: rtl/mdio_station_checker.sv
module mdio_station_checker #(
    parameter int HALF_DIV = 10
) (
    input logic clk,
    input logic rst,
    input logic cmd_we,
    input logic wr_pending,
    input logic rd_pending,
    input logic rd_valid,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    logic        mdc_d;
    logic [15:0] hc;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_d <= 1'b0;
            hc    <= 16'(HALF_DIV);
        end else begin
            mdc_d <= mdc;
            if (mdc != mdc_d)
                hc <= 16'd1;
            else if (hc < 16'(HALF_DIV))
                hc <= hc + 16'd1;
        end
    end

    assert_one_pending_R8: assert property (@(posedge clk) disable iff (rst)
        $countones({wr_pending, rd_pending}) <= 1);

    assert_no_read_under_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_pending && cmd_we) |=> !rd_pending);

    assert_no_write_under_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_pending && cmd_we) |=> !wr_pending);

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        (!wr_pending && !rd_pending) |-> (!mdio_oe && !mdc));

    assert_mdio_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(mdio_oe) && mdio_oe && (mdio_o != $past(mdio_o))) |-> ($past(mdc) && !mdc));

    assert_mdc_phase_R10: assert property (@(posedge clk) disable iff (rst)
        (mdc != mdc_d) |-> (hc >= 16'(HALF_DIV)));

    assert_valid_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        rd_pending |-> !rd_valid);
endmodule

bind mdio_station_master mdio_station_checker #(.HALF_DIV(HALF_DIV)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .cmd_we     (cmd_we),
    .wr_pending (wr_pending),
    .rd_pending (rd_pending),
    .rd_valid   (rd_valid),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
);

// File: tb/tb_mdio_station_master.sv
`timescale 1ns/1ps
module tb_mdio_station_master;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0, cfg_c45 = 0, cfg_pre_en = 0;
    logic        wd_we = 0;
    logic [15:0] wd_value = '0;
    logic        cmd_we = 0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_phy = '0, cmd_addr = '0;
    logic        wr_pending, rd_pending, rd_valid, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio_station_master #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_c45(cfg_c45), .cfg_pre_en(cfg_pre_en),
        .wd_we(wd_we), .wd_value(wd_value), .cmd_we(cmd_we), .cmd_op(cmd_op),
        .cmd_phy(cmd_phy), .cmd_addr(cmd_addr), .wr_pending(wr_pending),
        .rd_pending(rd_pending), .rd_valid(rd_valid), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [63:0] cap;
        int          ncap;
        bit          is_rd;
        bit          valid;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    logic [63:0] cap;
    int          ncap;
    int          redge;
    int          startpos;
    logic [17:0] resp;
    bit          phy_on;
    realtime     last_rise;
    realtime     min_per;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // bus monitor: capture driven bits on each MDC rising edge
    always @(posedge mdc) begin
        if (mdio_oe) begin
            cap = {cap[62:0], mdio_o};
            ncap++;
        end
        if (last_rise > 0 && ($realtime - last_rise) < min_per)
            min_per = $realtime - last_rise;
        last_rise = $realtime;
        redge++;
    end

    // PHY model: present the next reply bit after each MDC falling edge
    always @(negedge mdc) begin
        int p;
        p = startpos - redge;
        if (phy_on && p >= 0 && p <= 17) mdio_i = resp[p];
        else mdio_i = 1'b1;
    end

    // scoreboard monitor: compare when a frame completes
    logic busy_d = 1'b0;
    always @(negedge clk) begin
        logic busy_now;
        exp_t e;
        busy_now = wr_pending | rd_pending;
        if (busy_d && !busy_now) begin
            if (sbq.size() == 0) begin
                chk(0, "R8", "unexpected frame", 64'(ncap), 64'd0);
            end else begin
                e = sbq.pop_front();
                chk(cap == e.cap, e.tag, "frame bits", cap, e.cap);
                chk(ncap == e.ncap, "R4", "driven bit count", 64'(ncap), 64'(e.ncap));
                chk(min_per >= 400.0, "R10", "MDC period ns", 64'(int'(min_per)), 64'd400);
                if (e.is_rd) begin
                    chk(rd_valid == e.valid, "R7", "read valid", 64'(rd_valid), 64'(e.valid));
                    chk(rd_data == e.data, "R7", "read data", 64'(rd_data), 64'(e.data));
                end
            end
        end
        busy_d = busy_now;
    end

    function automatic logic [1:0] exp_wire(input bit c45, input logic [1:0] op);
        if (c45) return (op == 2'd0) ? 2'b00 : (op == 2'd1) ? 2'b01 : 2'b11;
        return (op == 2'd0) ? 2'b01 : 2'b10;
    endfunction

    task automatic run_frame(input bit c45, input bit pre, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] addr,
                             input logic [15:0] wd, input bit ta2, input logic [15:0] rdat,
                             input string tag);
        exp_t e;
        bit rd;
        logic [1:0] st;
        logic [31:0] fr;
        rd = c45 ? (op == 2'd3) : (op == 2'd1);
        st = c45 ? 2'b00 : 2'b01;
        fr = {st, exp_wire(c45, op), phy, addr, 2'b10, wd};
        @(negedge clk);
        cfg_we = 1; cfg_c45 = c45; cfg_pre_en = pre; wd_we = 1; wd_value = wd;
        @(negedge clk);
        cfg_we = 0; wd_we = 0;
        cap = '0; ncap = 0; redge = 0; last_rise = 0; min_per = 1.0e9;
        startpos = pre ? 63 : 31;
        resp = {1'b1, ta2, rdat};
        phy_on = rd;
        e.is_rd = rd; e.valid = !ta2; e.data = rdat; e.tag = tag;
        if (rd) begin
            e.cap  = pre ? 64'({32'hFFFF_FFFF, fr[31:18]}) : 64'(fr[31:18]);
            e.ncap = pre ? 46 : 14;
        end else begin
            e.cap  = pre ? {32'hFFFF_FFFF, fr} : 64'(fr);
            e.ncap = pre ? 64 : 32;
        end
        sbq.push_back(e);
        cmd_we = 1; cmd_op = op; cmd_phy = phy; cmd_addr = addr;
        @(negedge clk);
        cmd_we = 0;
        if (rd) begin
            chk(rd_pending && !wr_pending && !rd_valid, "R7", "read pending on start",
                64'({rd_pending, wr_pending, rd_valid}), 64'b100);
        end else begin
            chk(wr_pending && !rd_pending, "R6", "write pending on start",
                64'({wr_pending, rd_pending}), 64'b10);
        end
    endtask

    task automatic wait_idle();
        while (wr_pending || rd_pending) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    bit finished = 0;

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!wr_pending && !rd_pending && !rd_valid && !mdc && !mdio_oe, "R1", "reset state",
            64'({wr_pending, rd_pending, rd_valid, mdc, mdio_oe}), 64'd0);

        run_frame(0, 1, 2'd0, 5'h03, 5'h1A, 16'hA5C3, 1, 16'h0, "R2 R5 c22 write");
        wait_idle();
        run_frame(0, 1, 2'd1, 5'h11, 5'h02, 16'h0, 0, 16'h1234, "R2 c22 read");
        wait_idle();
        run_frame(0, 0, 2'd1, 5'h1F, 5'h05, 16'h0, 1, 16'hBEEF, "R7 R4 c22 read no reply");
        wait_idle();
        run_frame(1, 1, 2'd0, 5'h0A, 5'h01, 16'h8001, 1, 16'h0, "R3 c45 address");
        wait_idle();
        run_frame(1, 0, 2'd1, 5'h0A, 5'h07, 16'h3C5A, 1, 16'h0, "R3 R5 c45 write");
        wait_idle();
        run_frame(1, 1, 2'd3, 5'h15, 5'h1E, 16'h0, 0, 16'hFEDC, "R3 R7 c45 read");
        wait_idle();

        // R8: command during an active write frame is ignored
        run_frame(0, 0, 2'd0, 5'h04, 5'h09, 16'h00FF, 1, 16'h0, "R8 write before ignored cmd");
        repeat (50) @(negedge clk);
        cmd_we = 1; cmd_op = 2'd1; cmd_phy = 5'h1; cmd_addr = 5'h1;
        @(negedge clk);
        cmd_we = 0;
        chk(!rd_pending && wr_pending, "R8", "read cmd during write ignored",
            64'({rd_pending, wr_pending}), 64'b01);
        wait_idle();
        chk(!rd_pending && !wr_pending && sbq.size() == 0, "R8", "no extra frame",
            64'({rd_pending, wr_pending}), 64'd0);
        chk(rd_valid == 1'b1 && rd_data == 16'hFEDC, "R8", "read status untouched",
            64'({rd_valid, rd_data}), 64'({1'b1, 16'hFEDC}));

        // R9: unused opcodes start nothing
        @(negedge clk);
        cfg_we = 1; cfg_c45 = 1; cfg_pre_en = 0;
        @(negedge clk);
        cfg_we = 0; cmd_we = 1; cmd_op = 2'd2;
        @(negedge clk);
        cmd_we = 0;
        repeat (2 * HALF) @(negedge clk);
        chk(!wr_pending && !rd_pending && !mdio_oe && !mdc, "R9", "c45 op2 ignored",
            64'({wr_pending, rd_pending, mdio_oe, mdc}), 64'd0);
        cfg_we = 1; cfg_c45 = 0;
        @(negedge clk);
        cfg_we = 0; cmd_we = 1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_we = 0;
        repeat (2 * HALF) @(negedge clk);
        chk(!wr_pending && !rd_pending && !mdio_oe && rd_valid, "R9", "c22 op3 ignored",
            64'({wr_pending, rd_pending, mdio_oe, rd_valid}), 64'b0001);
        chk(sbq.size() == 0, "R9", "scoreboard drained", 64'(sbq.size()), 64'd0);
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (190000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule